// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Transmitter

This block is the transmit half of a clocked serial link operating as clock master. An external rate generator supplies a one-cycle baud tick. The block divides that tick by four to form a shift clock that runs continuously. A write port on the system side fills a one-word holding register. The word moves into a shift register and goes out least significant bit first on a data line, together with a serial clock line. A receiver samples the data line on the rising edge of that clock.

The holding register is separate from the shift register. Software can therefore queue the next word while the current frame is still going out. When a frame ends and a word is waiting, the block loads it by itself. It inserts one idle bit time and then starts the next frame. Two status outputs report the state of the transmitter. One shows that the holding register is free for a new write. The other is a sticky flag that shows the transmitter has run dry.

Top module: `sync_ser_tx`

## Requirements
- R1: The shift clock is the baud tick divided by `TICK_DIV` (default 4) and runs freely from reset. Within a frame, consecutive rising edges of `sclk_o` are exactly `TICK_DIV` ticks apart. `sclk_o` only changes in a cycle that follows a tick.
- R2: A cycle with `wr_en` high stores `wr_data` in the holding register. In the next cycle `buf_empty_o` reads 0 and `tx_done_o` reads 0. When the transmitter is idle, the word moves to the shift register one cycle after the write.
- R3: `buf_empty_o` returns to 1 in the cycle after the word moves from the holding register to the shift register.
- R4: The first data bit and the first low phase of `sclk_o` appear together, on the first falling shift-clock event after the load. This is 1 to `TICK_DIV` baud ticks after the load, depending on the divider phase.
- R5: A frame has `FRAME_W` bits, sent least significant bit first. Each bit is placed on `sdo_o` for a low half of `sclk_o` followed by a high half.
- R6: `sdo_o` changes only where `sclk_o` falls, or at the end of a frame. It never changes while `sclk_o` stays low, and it never changes at a rising edge of `sclk_o`.
- R7: If a word is waiting when a frame ends, the block loads it at that moment and sends it without further action. `tx_done_o` stays 0 throughout such a burst.
- R8: If no word is waiting when a frame ends, the transmitter goes idle and sets `tx_done_o`. While `tx_done_o` is 1, `buf_empty_o` is also 1.
- R9: Between back-to-back frames there is a gap of exactly one bit time. During the gap `sdo_o` is 1 and `sclk_o` is 1. Consecutive frame starts are therefore `(FRAME_W+1)*TICK_DIV` ticks apart.
- R10: While the transmitter is idle, and from reset, `sclk_o` and `sdo_o` are both 1. From reset, `buf_empty_o` is 1 and `tx_done_o` is 0.
- R11: `tx_done_o` stays set until `tc_clr` or `wr_en` is high. Either one clears the flag in the next cycle, even if a frame ends in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle rate pulse from the baud generator |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | FRAME_W | Word to transmit |
| tc_clr | input | 1 | Clears the transmit-complete flag |
| sclk_o | output | 1 | Serial clock, high when idle |
| sdo_o | output | 1 | Serial data, LSB first, high when idle |
| buf_empty_o | output | 1 | Holding register can take a new word |
| tx_done_o | output | 1 | Sticky flag: a frame ended with nothing queued |

## Verification
The bench measures the start delay in ticks from the observed load to the first falling clock edge. It expects a value from 1 to 4, so a design that realigned the divider on a write would show a fixed delay, and one that added a stage would show 5. In a three-word burst the bench checks that frame starts are exactly nine bit times apart. It also checks that the line is high in the middle of each gap and that the complete flag never rises between frames. A design that dropped the gap, left stale data in it, or raised the flag early fails these checks. Bit order, the stability of data across rising clock edges, and the rule that a write clears the flag are checked on every frame.

// File: rtl/sst_pkg.sv
// Package: shared types for the serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package sst_pkg;

    // Frame sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // nothing in the shifter
        ST_ARMED = 2'd1,  // word loaded, waiting for a falling event
        ST_SHIFT = 2'd2,  // bits on the line
        ST_GAP   = 2'd3   // one idle bit between frames
    } sst_state_e;

endpackage

// File: rtl/sst_baud_div.sv
// Module: free-running divider of the baud tick.
// Produces the shift clock level and a strobe for its falling event.
// The count moves only on ticks and is cleared only by reset.
// Assumes: DIV is even and at least 2.
module sst_baud_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic sck_lvl,
    output logic fall_evt
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_q;

    // Advance the phase count on every baud tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Low for the first half of the count, high for the second half
    assign sck_lvl  = (cnt_q >= HALF);
    assign fall_evt = tick && (cnt_q == LAST);
endmodule

// File: rtl/sst_hold_buf.sv
// Module: one-word holding register in front of the shifter.
// A write has priority over a take in the same cycle, so a word written
// while the old one is being taken stays pending.
// Assumes: take is asserted only when full_o is 1.
module sst_hold_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    // Capture a written word
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_o <= '0;
        else if (wr_en)
            data_o <= wr_data;
    end

    // Track whether a word is waiting
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_o <= 1'b0;
        else if (wr_en)
            full_o <= 1'b1;
        else if (take)
            full_o <= 1'b0;
    end
endmodule

// File: rtl/sst_shift_eng.sv
// Module: frame sequencer and shift register.
// Loads from the holding register, drives clock and data lines, inserts a
// one-bit gap between chained frames, and flags an end with nothing queued.
// Assumes: fall_evt is a one-cycle strobe in the last cycle of the high
// half of the shift clock, and sck_lvl is the shift clock level.
module sst_shift_eng
    import sst_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_evt,
    input  logic         sck_lvl,
    input  logic         buf_full,
    input  logic [W-1:0] buf_data,
    output logic         take,
    output logic         end_idle,
    output logic         sclk_o,
    output logic         sdo_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST_BIT = IW'(W - 1);

    sst_state_e    st_q;
    logic [W-1:0]  sh_q;
    logic [IW-1:0] bit_q;
    logic          last_bit;
    logic          frame_end;

    assign last_bit  = (bit_q == LAST_BIT);
    assign frame_end = (st_q == ST_SHIFT) && fall_evt && last_bit;
    assign take      = ((st_q == ST_IDLE) && buf_full) || (frame_end && buf_full);
    assign end_idle  = frame_end && !buf_full;

    // Sequence frames and shift the data out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            sh_q  <= '0;
            bit_q <= '0;
            sdo_o <= 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    sdo_o <= 1'b1;
                    if (buf_full) begin
                        sh_q <= buf_data;
                        st_q <= ST_ARMED;
                    end
                end
                ST_ARMED, ST_GAP: begin
                    if (fall_evt) begin
                        sdo_o <= sh_q[0];
                        sh_q  <= sh_q >> 1;
                        bit_q <= '0;
                        st_q  <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (fall_evt) begin
                        if (last_bit) begin
                            sdo_o <= 1'b1;
                            if (buf_full) begin
                                sh_q <= buf_data;
                                st_q <= ST_GAP;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end else begin
                            sdo_o <= sh_q[0];
                            sh_q  <= sh_q >> 1;
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // The clock line follows the shift clock only while bits are on the line
    assign sclk_o = (st_q == ST_SHIFT) ? sck_lvl : 1'b1;
endmodule

// File: rtl/sync_ser_tx.sv
// Module: top of the double-buffered clocked serial transmitter.
// Wires the divider, holding register and sequencer, and keeps the sticky
// transmit-complete flag.
// Assumes: baud_tick is a one-cycle pulse; clk is the only clock.
module sync_ser_tx #(
    parameter int FRAME_W  = 8,
    parameter int TICK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_tick,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               tc_clr,
    output logic               sclk_o,
    output logic               sdo_o,
    output logic               buf_empty_o,
    output logic               tx_done_o
);
    logic               sck_lvl;
    logic               fall_evt;
    logic               take;
    logic               end_idle;
    logic               buf_full;
    logic [FRAME_W-1:0] buf_data;

    sst_baud_div #(.DIV(TICK_DIV)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .sck_lvl  (sck_lvl),
        .fall_evt (fall_evt)
    );

    sst_hold_buf #(.W(FRAME_W)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .data_o  (buf_data),
        .full_o  (buf_full)
    );

    sst_shift_eng #(.W(FRAME_W)) eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_evt (fall_evt),
        .sck_lvl  (sck_lvl),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .take     (take),
        .end_idle (end_idle),
        .sclk_o   (sclk_o),
        .sdo_o    (sdo_o)
    );

    // Sticky complete flag; a write or a clear wins over a set
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_done_o <= 1'b0;
        else if (wr_en || tc_clr)
            tx_done_o <= 1'b0;
        else if (end_idle)
            tx_done_o <= 1'b1;
    end

    assign buf_empty_o = !buf_full;
endmodule

// File: rtl/sst_tx_chk.sv
// Module: property checker for sync_ser_tx, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module sst_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic wr_en,
    input logic tc_clr,
    input logic sclk_o,
    input logic sdo_o,
    input logic buf_empty_o,
    input logic tx_done_o
);
    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_o) |-> $past(baud_tick)); // R1

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!buf_empty_o && !tx_done_o)); // R2

    AST_SDO_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && $past(!sclk_o)) |-> $stable(sdo_o)); // R6

    AST_SDO_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdo_o)); // R6

    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> buf_empty_o); // R8

    AST_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_clr |=> !tx_done_o); // R11
endmodule

bind sync_ser_tx sst_tx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick),
    .wr_en       (wr_en),
    .tc_clr      (tc_clr),
    .sclk_o      (sclk_o),
    .sdo_o       (sdo_o),
    .buf_empty_o (buf_empty_o),
    .tx_done_o   (tx_done_o)
);

// File: tb/sync_ser_tx_tb_top.sv
`timescale 1ns/1ps
module sync_ser_tx_tb_top;
    localparam int W   = 8;
    localparam int DIV = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         baud_tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         tc_clr = 1'b0;
    logic         sclk_o, sdo_o, buf_empty_o, tx_done_o;

    int n_chk = 0;
    int n_bad = 0;
    int tick_count = 0;

    // monitor state
    logic         prev_sclk = 1'b1;
    logic         prev_sdo  = 1'b1;
    logic [W-1:0] rx_sh = '0;
    int           rx_cnt = 0;
    int           rx_n = 0;
    int           nstart = 0;
    logic [W-1:0] rx_q [16];
    int           ff_tick [16];
    int           last_rise_tick = 0;
    int           rise_sdo_bad = 0;
    int           period_bad = 0;
    int           period_seen = 0;
    logic         gap_sdo = 1'b0;
    logic         gap_sclk = 1'b0;

    sync_ser_tx #(.FRAME_W(W), .TICK_DIV(DIV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .tc_clr      (tc_clr),
        .sclk_o      (sclk_o),
        .sdo_o       (sdo_o),
        .buf_empty_o (buf_empty_o),
        .tx_done_o   (tx_done_o)
    );

    always #5 clk = ~clk;

    // baud tick: one cycle in three
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            baud_tick = 1'b1;
            tick_count++;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    // line monitor: decodes frames and timing
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (!prev_sclk && sclk_o) begin
                if (sdo_o !== prev_sdo) rise_sdo_bad++;
                if (rx_cnt > 0) begin
                    period_seen++;
                    if (tick_count - last_rise_tick != DIV) period_bad++;
                end
                last_rise_tick = tick_count;
                rx_sh = {sdo_o, rx_sh[W-1:1]};
                rx_cnt++;
                if (rx_cnt == W) begin
                    if (rx_n < 16) rx_q[rx_n] = rx_sh;
                    rx_n++;
                    rx_cnt = 0;
                end
            end
            if (prev_sclk && !sclk_o && rx_cnt == 0) begin
                if (nstart < 16) ff_tick[nstart] = tick_count;
                nstart++;
            end
            if (nstart > 0 && tick_count == ff_tick[nstart-1] + W*DIV + DIV/2) begin
                gap_sdo  = sdo_o;
                gap_sclk = sclk_o;
            end
        end
        prev_sclk = sclk_o;
        prev_sdo  = sdo_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample();
        @(posedge clk);
        #2;
    endtask

    // write one word; checks the cycle right after the write (R2)
    task automatic do_write(input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        sample();
        check(!buf_empty_o, "R2 empty after write", buf_empty_o, 0);
        check(!tx_done_o, "R2 done after write", tx_done_o, 0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rx(input int n, output int done_seen);
        done_seen = 0;
        for (int i = 0; i < 2000 && rx_n < n; i++) begin
            sample();
            if (tx_done_o) done_seen++;
        end
    endtask

    task automatic t_reset();
        check(sclk_o === 1'b1, "R10 reset sclk", sclk_o, 1);
        check(sdo_o === 1'b1, "R10 reset sdo", sdo_o, 1);
        check(buf_empty_o === 1'b1, "R10 reset empty", buf_empty_o, 1);
        check(tx_done_o === 1'b0, "R10 reset done", tx_done_o, 0);
    endtask

    task automatic t_single(input logic [W-1:0] d, input int phase);
        int base, tl, ds;
        repeat (phase) @(negedge clk);
        base = rx_n;
        do_write(d);
        sample();
        check(buf_empty_o === 1'b1, "R3 empty after load", buf_empty_o, 1);
        tl = tick_count;
        wait_rx(base + 1, ds);
        check(rx_q[base] == d, "R5 frame data", rx_q[base], d);
        check(ff_tick[base] - tl >= 1 && ff_tick[base] - tl <= DIV,
              "R4 start latency", ff_tick[base] - tl, DIV);
        repeat (3 * DIV + 4) sample();
        check(tx_done_o === 1'b1, "R8 done after frame", tx_done_o, 1);
        check(sclk_o === 1'b1 && sdo_o === 1'b1, "R10 idle lines", {sclk_o, sdo_o}, 3);
        check(buf_empty_o === 1'b1, "R8 empty when done", buf_empty_o, 1);
    endtask

    task automatic t_clear();
        @(negedge clk);
        tc_clr = 1'b1;
        sample();
        check(tx_done_o === 1'b0, "R11 clear", tx_done_o, 0);
        @(negedge clk);
        tc_clr = 1'b0;
        repeat (5) sample();
        check(tx_done_o === 1'b0, "R11 stays clear", tx_done_o, 0);
    endtask

    task automatic t_burst(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        int base, ds, g;
        base = rx_n;
        do_write(a);
        for (int i = 0; i < 50 && !buf_empty_o; i++) sample();
        do_write(b);
        for (int i = 0; i < 500 && !buf_empty_o; i++) sample();
        do_write(c);
        for (int i = 0; i < 2000 && nstart < base + 2; i++) sample();
        check(gap_sdo === 1'b1 && gap_sclk === 1'b1, "R9 gap lines", {gap_sclk, gap_sdo}, 3);
        wait_rx(base + 2, ds);
        g = ds;
        wait_rx(base + 3, ds);
        check(g + ds == 0, "R7 no done inside burst", g + ds, 0);
        check(rx_q[base] == a, "R7 frame 1", rx_q[base], a);
        check(rx_q[base+1] == b, "R7 frame 2", rx_q[base+1], b);
        check(rx_q[base+2] == c, "R7 frame 3", rx_q[base+2], c);
        check(ff_tick[base+1] - ff_tick[base] == (W + 1) * DIV, "R9 spacing 1-2",
              ff_tick[base+1] - ff_tick[base], (W + 1) * DIV);
        check(ff_tick[base+2] - ff_tick[base+1] == (W + 1) * DIV, "R9 spacing 2-3",
              ff_tick[base+2] - ff_tick[base+1], (W + 1) * DIV);
        repeat (3 * DIV + 4) sample();
        check(tx_done_o === 1'b1, "R8 done after burst", tx_done_o, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        sample();
        t_reset();
        t_single(8'hA5, 0);
        t_clear();
        t_single(8'h3C, 1);
        t_single(8'h81, 2);
        t_burst(8'h5A, 8'hF0, 8'h0F);
        check(rise_sdo_bad == 0, "R6 data stable at rise", rise_sdo_bad, 0);
        check(period_seen > 0 && period_bad == 0, "R1 bit period", period_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule